// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes from a host into asynchronous serial frames on one output line. Each frame has eleven bit periods: a low start bit, the eight data bits with bit 0 first, an odd parity bit and a high stop bit. The line runs at 9600 baud by default. The bit period is derived from the clock frequency parameter.

There are two storage stages. A host write lands in a one-byte holding buffer. Whenever the shift stage is free, the logic moves the held byte into it without any host action. This lets the host queue the next byte while the current frame is still on the wire, and frames then follow each other with no idle time. A three-bit status word reports the state of each stage: bit 2 is high while the holding buffer is empty, and bit 1 is high while the shift stage is empty.

Top module: `uatx_top`

## Requirements
- R1: While reset is held and after it is released, `tx_out` is 1 and `status` reads 3'b110.
- R2: The status word is active high. Bit 2 is holding-buffer-empty, bit 1 is shifter-empty and bit 0 always reads 0.
- R3: A frame is sent in this order: a start bit of 0, data bits 0 to 7 in that order, the parity bit, then a stop bit of 1.
- R4: The parity bit makes the count of ones across the eight data bits and the parity bit odd.
- R5: Every bit period lasts CLK_HZ/BAUD clock cycles, and a frame holds `tx_out` for exactly 11 such periods. The default BAUD is 9600.
- R6: A write accepted while both stages are empty clears status bit 2 for exactly one cycle. On the next cycle the byte is in the shifter: bit 1 reads 0, bit 2 reads 1 again and the start bit is on `tx_out`.
- R7: A write accepted while a frame is being sent stays in the holding buffer, with status bit 2 at 0, until that frame ends. It does not change the frame in progress.
- R8: A write while the holding buffer is already full replaces the pending byte. The replaced byte is never sent.
- R9: If the buffer is full when a stop bit ends, the next start bit begins on the very next cycle, with no idle time between the frames.
- R10: Whenever the shifter is empty, `tx_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding buffer, one cycle per byte |
| wr_data | input | 8 | Byte to transmit |
| tx_out | output | 1 | Serial line output, idles high |
| status | output | 3 | Bit 2 buffer empty, bit 1 shifter empty, bit 0 zero |

## Verification
The assertions assume that `wr_en` is a clean single-cycle strobe, synchronous to `clk`, and that reset is released away from a clock edge. They also assume that the host may write at any time, including while the buffer is full.

The stimulus drives every input on the falling edge and keeps each strobe to one cycle. The bench overrides the clock frequency so that a bit period is eight cycles. It then samples the line in the middle of each bit period. Its writes include a write into an idle block, a write during a frame, and a second write that lands on a full buffer.

// File: rtl/uatx_pkg.sv
package uatx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

    typedef logic [7:0]            byte_t;
    typedef logic [FRAME_BITS-1:0] frame_t;

    // Parity bit that makes data plus parity hold an odd count of ones.
    function automatic logic odd_parity(input byte_t d);
        return ~(^d);
    endfunction

    // Builds the frame, least significant bit first on the line.
    function automatic frame_t build_frame(input byte_t d);
        return {1'b1, odd_parity(d), d, 1'b0};
    endfunction
endpackage

// File: rtl/uatx_baud_gen.sv
module uatx_baud_gen #(
    parameter int CLKS_PER_BIT = 5208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLKS_PER_BIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } baud_state_t;

    baud_state_t st_d, st_q;
    logic        at_max;

    always_comb begin
        st_d   = st_q;
        at_max = (st_q.cnt == CNT_MAX);
        tick_o = run_i && at_max;
        if (!run_i || at_max) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uatx_hold_buf.sv
module uatx_hold_buf
    import uatx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en_i,
    input  byte_t wr_data_i,
    input  logic  take_i,
    output byte_t data_o,
    output logic  full_o
);
    typedef struct packed {
        logic  full;
        byte_t data;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            // A new write wins over a take in the same cycle and replaces any pending byte.
            st_d.full = 1'b1;
            st_d.data = wr_data_i;
        end else if (take_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign full_o = st_q.full;

    assert_write_replaces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (full_o && data_o == $past(wr_data_i)));

    assert_held_until_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !take_i && !wr_en_i) |=> (full_o && $stable(data_o)));
endmodule

// File: rtl/uatx_shifter.sv
module uatx_shifter
    import uatx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  avail_i,
    input  byte_t avail_data_i,
    output logic  take_o,
    output logic  busy_o,
    output logic  tx_o
);
    localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                 busy;
        logic [BIT_IDX_W-1:0] idx;
        frame_t               shreg;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         on_last;
    logic         frame_done;
    logic         free_slot;

    always_comb begin
        st_d       = st_q;
        on_last    = (st_q.idx == LAST_IDX);
        frame_done = st_q.busy && tick_i && on_last;
        free_slot  = !st_q.busy || frame_done;
        take_o     = free_slot && avail_i;
        if (take_o) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.shreg = build_frame(avail_data_i);
        end else if (st_q.busy && tick_i) begin
            if (on_last) begin
                st_d.busy  = 1'b0;
                st_d.idx   = '0;
                st_d.shreg = '1;
            end else begin
                st_d.idx   = st_q.idx + 1'b1;
                st_d.shreg = {1'b1, st_q.shreg[FRAME_BITS-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.idx   <= '0;
            st_q.shreg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign tx_o   = st_q.shreg[0];

    assert_idle_line_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

    assert_bit_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> $stable(tx_o));

    assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tick_i && on_last && avail_i) |=> (busy_o && !tx_o));

    assert_start_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !tx_o);
endmodule

// File: rtl/uatx_top.sv
module uatx_top
    import uatx_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       tx_out,
    output logic [2:0] status
);
    localparam int CLKS_PER_BIT = CLK_HZ / BAUD;

    logic  tick;
    logic  take;
    logic  busy;
    logic  held;
    byte_t held_data;

    uatx_baud_gen #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) baud_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .tick_o (tick)
    );

    uatx_hold_buf hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .take_i    (take),
        .data_o    (held_data),
        .full_o    (held)
    );

    uatx_shifter shift_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .avail_i      (held),
        .avail_data_i (held_data),
        .take_o       (take),
        .busy_o       (busy),
        .tx_o         (tx_out)
    );

    assign status = {!held, !busy, 1'b0};

    assert_auto_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[2] && status[1]) |=> !status[1]);

    assert_buffer_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[2] && !status[1] && !tick && !wr_en) |=> !status[2]);
endmodule

// File: tb/uatx_top_tb_top.sv
module uatx_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TB_BAUD    = 9600;
    localparam int TB_CLK_HZ  = TB_BAUD * 8;
    localparam int BIT_CLKS   = TB_CLK_HZ / TB_BAUD;
    localparam int HALF_BIT   = BIT_CLKS / 2;
    localparam int NVEC       = 8;
    // Each entry is {expected parity, data byte}.
    localparam logic [8:0] VEC_TAB [NVEC] = '{
        9'h100, 9'h1FF, 9'h001, 9'h1A5, 9'h080, 9'h07F, 9'h13C, 9'h15A
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_out;
    logic [2:0] status;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    uatx_top #(
        .CLK_HZ (TB_CLK_HZ),
        .BAUD   (TB_BAUD)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tx_out  (tx_out),
        .status  (status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called on a falling edge; returns on the falling edge after the capturing edge.
    task automatic write_byte(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Waits first_wait falling edges, then samples 11 bit midpoints.
    task automatic check_frame(input logic [7:0] d, input logic par, input int first_wait);
        logic [10:0] exp;
        exp = {1'b1, par, d, 1'b0};
        repeat (first_wait) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            if (i > 0) repeat (BIT_CLKS) @(negedge clk);
            if (i == 0)       chk("R3 start bit", int'(tx_out), 0);
            else if (i == 9)  chk("R4 parity bit", int'(tx_out), int'(exp[i]));
            else if (i == 10) chk("R3 stop bit", int'(tx_out), 1);
            else              chk("R3 data bit", int'(tx_out), int'(exp[i]));
            if (i == 5) chk("R2 shifter busy flag", int'(status[1]), 0);
        end
    endtask

    // Called just after the stop-bit sample of the last frame.
    task automatic check_frame_end();
        repeat (HALF_BIT - 1) @(negedge clk);
        chk("R5 frame still active", int'(status[1]), 0);
        @(negedge clk);
        chk("R5 frame length", int'(status[1]), 1);
        chk("R10 idle high", int'(tx_out), 1);
        chk("R2 status idle", int'(status), 3'b110);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset line", int'(tx_out), 1);
        chk("R1 reset status", int'(status), 3'b110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after reset status", int'(status), 3'b110);
        chk("R1 after reset line", int'(tx_out), 1);

        // Table walk: one frame from idle per entry.
        for (int v = 0; v < NVEC; v++) begin
            write_byte(VEC_TAB[v][7:0]);
            chk("R6 buffer flag low", int'(status[2]), 0);
            @(negedge clk);
            chk("R6 buffer flag back", int'(status[2]), 1);
            chk("R6 shifter loaded", int'(status[1]), 0);
            check_frame(VEC_TAB[v][7:0], VEC_TAB[v][8], HALF_BIT);
            check_frame_end();
            repeat (3) @(negedge clk);
        end

        // Back-to-back frames: second byte queued during the first.
        write_byte(8'hC3);
        @(negedge clk);
        write_byte(8'h96);
        chk("R7 byte held while busy", int'(status), 3'b000);
        check_frame(8'hC3, ~(^8'hC3), HALF_BIT - 1);
        check_frame(8'h96, ~(^8'h96), BIT_CLKS);
        chk("R9 buffer drained", int'(status[2]), 1);
        check_frame_end();
        repeat (3) @(negedge clk);

        // Overwrite of a pending byte.
        write_byte(8'h11);
        @(negedge clk);
        write_byte(8'h22);
        write_byte(8'hE7);
        chk("R8 buffer still full", int'(status[2]), 0);
        check_frame(8'h11, ~(^8'h11), HALF_BIT - 2);
        check_frame(8'hE7, ~(^8'hE7), BIT_CLKS);
        check_frame_end();
        repeat (BIT_CLKS * 3) @(negedge clk);
        chk("R8 replaced byte not sent", int'(status), 3'b110);
        chk("R10 line stays high", int'(tx_out), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule